// File: doc/BRIEF.md
# Iterative Signed/Unsigned Multiplier with HI/LO Result Registers

This block multiplies two 32-bit operands over several clock cycles and leaves the 64-bit product in two result words. The upper half goes into HI and the lower half into LO. One mode flag chooses between a two's-complement product and an unsigned product, so the same hardware serves both kinds of multiply instruction.

A request is a single-cycle start strobe, presented together with the operands and the mode flag. The block handles it in steps:

- In signed mode, each negative operand is turned into its magnitude first. The sign of the result is kept aside.
- Operand A is the multiplier. Its bits are scanned from the least significant end, one bit per cycle. For each 1 bit, the current shifted copy of operand B is added into a 64-bit accumulator.
- The scan stops on the highest set bit of the multiplier magnitude.
- A negative result takes one extra cycle, in which the 64-bit value is negated.
- If either operand is zero, the loop is skipped and both result words are cleared at once.

A client waits for the done pulse before reading HI and LO. It may issue the next request in the same cycle that done is high.

Top module: `imul_hilo`

## Requirements
- R1: While reset is held and after it is released, hi_o and lo_o are zero and busy_o and done_o are low.
- R2: A start that is accepted with op_a_i or op_b_i equal to zero sets hi_o and lo_o to zero and raises done_o in the next cycle. busy_o never goes high for that request.
- R3: With signed_i low, {hi_o, lo_o} at completion equals the unsigned 64-bit product of op_a_i and op_b_i.
- R4: With signed_i high, {hi_o, lo_o} at completion equals the two's-complement 64-bit product of op_a_i and op_b_i. The result is negative exactly when the operand sign bits (bit 31) differ and neither operand is zero.
- R5: For nonzero operands, busy_o is high starting in the cycle after the accepting edge. It stays high for k cycles, plus one more when the result is negative. Here k is one plus the index of the highest set bit of the magnitude of op_a_i (the magnitude is op_a_i itself in unsigned mode).
- R6: done_o is high for exactly one cycle per request. It rises on the same edge that updates hi_o and lo_o and that drops busy_o, and it is never high together with busy_o.
- R7: A start while busy_o is high is ignored. The running result, its sign and its latency do not change.
- R8: hi_o and lo_o keep their value in every cycle in which done_o is low.
- R9: A start is accepted in the cycle in which done_o is high, so requests can run back to back.
- R10: Operand 0x80000000 in signed mode is treated as magnitude 2^31. For example, 0x80000000 times 0x80000000 gives HI=0x40000000, LO=0, and 0x80000000 times 0xFFFFFFFF gives HI=0, LO=0x80000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, taken only when busy_o is low |
| signed_i | input | 1 | 1 = two's-complement multiply, 0 = unsigned |
| op_a_i | input | 32 | Multiplier operand |
| op_b_i | input | 32 | Multiplicand operand |
| hi_o | output | 32 | Upper word of the product |
| lo_o | output | 32 | Lower word of the product |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Two functions can fall in the same cycle:

- **Back-to-back start.** The completion of one request (done high, HI/LO just written) can coincide with the acceptance of the next start. The bench provokes this by waiting for done to appear and then holding start in that very cycle. The follow-on request can be a nonzero product or a zero operand, which completes again in the next cycle.
- **Start while busy.** Starts that carry different operands and modes are also driven in the middle of a running request, to show they do not disturb it.

A behavioural model in the bench works out the latency from the highest set bit of the multiplier magnitude and the product from integer arithmetic. It compares busy, done, HI and LO against the outputs in every cycle.

// File: rtl/imul_pkg.sv
package imul_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_NEG  = 2'd2
  } imul_state_e;

endpackage

// File: rtl/imul_prep.sv
// Operand conditioning: sign-magnitude conversion, result sign, zero detect.
module imul_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  input  logic         signed_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output logic         neg_o,
  output logic         zero_o
);

  localparam int SB = W - 1;

  logic a_neg, b_neg;

  always_comb begin
    a_neg   = signed_i & op_a_i[SB];
    b_neg   = signed_i & op_b_i[SB];
    mag_a_o = a_neg ? (~op_a_i + {{(W-1){1'b0}}, 1'b1}) : op_a_i;
    mag_b_o = b_neg ? (~op_b_i + {{(W-1){1'b0}}, 1'b1}) : op_b_i;
    zero_o  = (op_a_i == '0) | (op_b_i == '0);
    neg_o   = (a_neg ^ b_neg) & ~zero_o;
  end

endmodule

// File: rtl/imul_core.sv
// Shift-and-add engine: one multiplier bit per step, two-word accumulator.
module imul_core #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         step_i,
  input  logic [W-1:0] mplier_i,
  input  logic [W-1:0] mcand_i,
  output logic         last_o,
  output logic [W-1:0] sum_hi_o,
  output logic [W-1:0] sum_lo_o,
  output logic [W-1:0] acc_hi_o,
  output logic [W-1:0] acc_lo_o
);

  localparam int SB = W - 1;

  logic [W-1:0] mc_hi_q, mc_hi_d;
  logic [W-1:0] mc_lo_q, mc_lo_d;
  logic [W-1:0] mp_q, mp_d;
  logic [W-1:0] acc_hi_q, acc_hi_d;
  logic [W-1:0] acc_lo_q, acc_lo_d;
  logic [W:0]   lo_ext;
  logic         lo_carry;
  logic         reg_en;

  // low-word add with its carry feeding the high word
  always_comb begin
    lo_ext   = {1'b0, acc_lo_q} + {1'b0, mc_lo_q};
    lo_carry = lo_ext[W];
    if (mp_q[0]) begin
      sum_lo_o = lo_ext[SB:0];
      sum_hi_o = acc_hi_q + mc_hi_q + {{(W-1){1'b0}}, lo_carry};
    end else begin
      sum_lo_o = acc_lo_q;
      sum_hi_o = acc_hi_q;
    end
    last_o = mp_q[0] & (mp_q[SB:1] == '0);
  end

  always_comb begin
    reg_en   = load_i | step_i;
    mc_hi_d  = mc_hi_q;
    mc_lo_d  = mc_lo_q;
    mp_d     = mp_q;
    acc_hi_d = acc_hi_q;
    acc_lo_d = acc_lo_q;
    if (load_i) begin
      mc_hi_d  = '0;
      mc_lo_d  = mcand_i;
      mp_d     = mplier_i;
      acc_hi_d = '0;
      acc_lo_d = '0;
    end else if (step_i) begin
      acc_hi_d = sum_hi_o;
      acc_lo_d = sum_lo_o;
      mc_hi_d  = {mc_hi_q[SB-1:0], mc_lo_q[SB]};
      mc_lo_d  = {mc_lo_q[SB-1:0], 1'b0};
      mp_d     = {1'b0, mp_q[SB:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mc_hi_q  <= '0;
      mc_lo_q  <= '0;
      mp_q     <= '0;
      acc_hi_q <= '0;
      acc_lo_q <= '0;
    end else if (reg_en) begin
      mc_hi_q  <= mc_hi_d;
      mc_lo_q  <= mc_lo_d;
      mp_q     <= mp_d;
      acc_hi_q <= acc_hi_d;
      acc_lo_q <= acc_lo_d;
    end
  end

  assign acc_hi_o = acc_hi_q;
  assign acc_lo_o = acc_lo_q;

  // R5: each step consumes exactly one multiplier bit
  a_r5_mplier_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> (mp_q == ($past(mp_q) >> 1)));

  // R3: magnitudes only, so the accumulator never decreases while stepping
  a_r3_acc_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !load_i) |=> ({acc_hi_q, acc_lo_q} >= $past({acc_hi_q, acc_lo_q})));

endmodule

// File: rtl/imul_negate.sv
// Two-word two's complement: invert both words, bump LO, carry into HI on wrap.
module imul_negate #(
  parameter int W = 32
) (
  input  logic [W-1:0] in_hi_i,
  input  logic [W-1:0] in_lo_i,
  output logic [W-1:0] out_hi_o,
  output logic [W-1:0] out_lo_o
);

  logic lo_wrap;

  always_comb begin
    out_lo_o = ~in_lo_i + {{(W-1){1'b0}}, 1'b1};
    lo_wrap  = (out_lo_o == '0);
    out_hi_o = ~in_hi_i + {{(W-1){1'b0}}, lo_wrap};
  end

endmodule

// File: rtl/imul_hilo.sv
// Iterative multiplier control and HI/LO result registers.
module imul_hilo
  import imul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  output logic [W-1:0] hi_o,
  output logic [W-1:0] lo_o,
  output logic         busy_o,
  output logic         done_o
);

  imul_state_e  state_q, state_d;
  logic [W-1:0] hi_q, hi_d, lo_q, lo_d;
  logic         done_q, done_d;
  logic         neg_q, neg_d;
  logic         res_en;

  logic [W-1:0] mag_a, mag_b;
  logic         op_neg, op_zero;
  logic         accept, core_load, core_step, core_last;
  logic [W-1:0] sum_hi, sum_lo, acc_hi, acc_lo, neg_hi, neg_lo;

  imul_prep #(.W(W)) u_prep (
    .op_a_i   (op_a_i),
    .op_b_i   (op_b_i),
    .signed_i (signed_i),
    .mag_a_o  (mag_a),
    .mag_b_o  (mag_b),
    .neg_o    (op_neg),
    .zero_o   (op_zero)
  );

  imul_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (core_load),
    .step_i   (core_step),
    .mplier_i (mag_a),
    .mcand_i  (mag_b),
    .last_o   (core_last),
    .sum_hi_o (sum_hi),
    .sum_lo_o (sum_lo),
    .acc_hi_o (acc_hi),
    .acc_lo_o (acc_lo)
  );

  imul_negate #(.W(W)) u_neg (
    .in_hi_i  (acc_hi),
    .in_lo_i  (acc_lo),
    .out_hi_o (neg_hi),
    .out_lo_o (neg_lo)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    hi_d      = hi_q;
    lo_d      = lo_q;
    done_d    = 1'b0;
    neg_d     = neg_q;
    res_en    = 1'b0;
    core_load = 1'b0;
    core_step = 1'b0;
    accept    = start_i && (state_q == ST_IDLE);
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (op_zero) begin
            hi_d   = '0;
            lo_d   = '0;
            res_en = 1'b1;
            done_d = 1'b1;
          end else begin
            core_load = 1'b1;
            neg_d     = op_neg;
            state_d   = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        core_step = 1'b1;
        if (core_last) begin
          if (neg_q) begin
            state_d = ST_NEG;
          end else begin
            hi_d    = sum_hi;
            lo_d    = sum_lo;
            res_en  = 1'b1;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      ST_NEG: begin
        hi_d    = neg_hi;
        lo_d    = neg_lo;
        res_en  = 1'b1;
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      neg_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      neg_q   <= neg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (res_en) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign hi_o   = hi_q;
  assign lo_o   = lo_q;
  assign done_o = done_q;
  assign busy_o = (state_q != ST_IDLE);

  // R2: zero operand clears the result at once, no busy phase
  a_r2_zero_shortcut: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && ((op_a_i == '0) || (op_b_i == '0)))
      |=> (done_o && !busy_o && (hi_o == '0) && (lo_o == '0)));

  // R5: nonzero request goes busy on the next cycle
  a_r5_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && (op_a_i != '0) && (op_b_i != '0)) |=> (busy_o && !done_o));

  // R6: done and busy are exclusive
  a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R6: busy only falls together with done
  a_r6_fall_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R8: result words only move on completion
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> ($stable(hi_o) && $stable(lo_o)));

  // R7: a start while busy leaves the pending sign untouched
  a_r7_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> (neg_q == $past(neg_q)));

endmodule

// File: tb/imul_hilo_test.sv
module imul_hilo_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic        signed_i;
  logic [31:0] op_a_i, op_b_i;
  logic [31:0] hi_o, lo_o;
  logic        busy_o, done_o;

  int checks = 0;
  int errors = 0;

  // behavioural reference state
  logic        m_busy, m_done;
  logic [31:0] m_hi, m_lo;
  int          m_cnt;
  logic [63:0] m_res;
  string       m_tag = "R1";

  always #5 clk = ~clk;

  imul_hilo uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .signed_i (signed_i),
    .op_a_i   (op_a_i),
    .op_b_i   (op_b_i),
    .hi_o     (hi_o),
    .lo_o     (lo_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  function automatic logic [63:0] ref_prod(logic [31:0] a, logic [31:0] b, logic s);
    longint sa, sb;
    logic [63:0] ua, ub;
    if (s) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      return 64'(sa * sb);
    end
    ua = {32'd0, a};
    ub = {32'd0, b};
    return ua * ub;
  endfunction

  function automatic int ref_lat(logic [31:0] a, logic [31:0] b, logic s);
    logic [31:0] mag;
    int k = 0;
    mag = (s && a[31]) ? (-a) : a;
    for (int i = 0; i < 32; i++) if (mag[i]) k = i + 1;
    if (s && (a[31] ^ b[31])) k = k + 1;
    return k;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 1'b0; m_done = 1'b0; m_hi = '0; m_lo = '0; m_cnt = 0;
    end else begin
      m_done = 1'b0;
      if (!m_busy) begin
        if (start_i) begin
          if (op_a_i == 0 || op_b_i == 0) begin
            m_hi = '0; m_lo = '0; m_done = 1'b1; m_tag = "R2";
          end else begin
            m_busy = 1'b1;
            m_cnt  = ref_lat(op_a_i, op_b_i, signed_i);
            m_res  = ref_prod(op_a_i, op_b_i, signed_i);
            m_tag  = signed_i ? "R4" : "R3";
          end
        end
      end else begin
        m_cnt = m_cnt - 1;
        if (m_cnt == 0) begin
          m_busy = 1'b0; m_done = 1'b1;
          m_hi = m_res[63:32]; m_lo = m_res[31:0];
        end
      end
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5", 64'(busy_o), 64'(m_busy));
      chk("R6", 64'(done_o), 64'(m_done));
      chk(m_tag, {hi_o, lo_o}, {m_hi, m_lo});
    end
  end

  task automatic issue(logic [31:0] a, logic [31:0] b, logic s);
    @(posedge clk); #2;
    start_i = 1'b1; op_a_i = a; op_b_i = b; signed_i = s;
    @(posedge clk); #2;
    start_i = 1'b0;
  endtask

  task automatic drain();
    while (m_busy || m_done) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic run_op(logic [31:0] a, logic [31:0] b, logic s);
    issue(a, b, s);
    drain();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] corners [5];
    logic [63:0] held;
    corners[0] = 32'h0; corners[1] = 32'h1; corners[2] = 32'hFFFFFFFF;
    corners[3] = 32'h80000000; corners[4] = 32'h7FFFFFFF;
    rst_n = 1'b0; start_i = 1'b0; signed_i = 1'b0; op_a_i = '0; op_b_i = '0;
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk("R1", {hi_o, lo_o, 30'd0, busy_o, done_o}, 96'd0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #3 chk("R1", {hi_o, lo_o, 30'd0, busy_o, done_o}, 96'd0);

    // R10: most negative operand
    run_op(32'h80000000, 32'h80000000, 1'b1);
    chk("R10", {hi_o, lo_o}, 64'h4000000000000000);
    run_op(32'h80000000, 32'hFFFFFFFF, 1'b1);
    chk("R10", {hi_o, lo_o}, 64'h0000000080000000);
    // R3: unsigned all-ones squared
    run_op(32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0);
    chk("R3", {hi_o, lo_o}, 64'hFFFFFFFE00000001);
    // R4: -1 * 7
    run_op(32'hFFFFFFFF, 32'd7, 1'b1);
    chk("R4", {hi_o, lo_o}, 64'hFFFFFFFFFFFFFFF9);
    // R2: zero shortcut
    run_op(32'd0, 32'h12345678, 1'b1);
    chk("R2", {hi_o, lo_o}, 64'd0);

    // corner sweep, both modes
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 5; i++)
        for (int j = 0; j < 5; j++)
          run_op(corners[i], corners[j], s[0]);

    // R7: starts while busy are ignored
    issue(32'h80001234, 32'hDEADBEEF, 1'b1);
    @(posedge clk); #2;
    start_i = 1'b1; op_a_i = 32'd0; op_b_i = 32'd5; signed_i = 1'b0;
    @(posedge clk); #2;
    op_a_i = 32'd3; op_b_i = 32'd3;
    @(posedge clk); #2;
    start_i = 1'b0;
    drain();
    chk("R7", {hi_o, lo_o}, ref_prod(32'h80001234, 32'hDEADBEEF, 1'b1));

    // R8: result held while idle
    held = {hi_o, lo_o};
    repeat (5) @(posedge clk);
    #3 chk("R8", {hi_o, lo_o}, held);

    // R9: back-to-back start in the done cycle, nonzero then zero follow-on
    for (int n = 0; n < 2; n++) begin
      issue(32'h00F0F0F1, 32'h11111111, 1'b0);
      while (!m_done) begin
        @(posedge clk); #1;
      end
      #1;
      start_i = 1'b1; op_a_i = (n == 0) ? 32'h00000033 : 32'd0;
      op_b_i = 32'hFFFF0000; signed_i = 1'b1;
      @(posedge clk); #2;
      start_i = 1'b0;
      chk("R9", 64'((n == 0) ? busy_o : done_o), 64'd1);
      drain();
    end
    chk("R9", {hi_o, lo_o}, 64'd0);

    // random operands, both modes, varied multiplier widths
    for (int r = 0; r < 160; r++) begin
      logic [31:0] a, b;
      a = $urandom() >> ($urandom() % 32);
      b = $urandom();
      run_op(a, b, r[0]);
    end

    repeat (3) @(posedge clk);
    finish_run();
  end

endmodule